// File: doc/BRIEF.md
# Predictive Inverter Voltage-Vector Selector

This block picks, once per sampling period, one of the eight switching states of a three-phase two-level inverter. Each sample gives it several quantities in stationary two-axis fixed point: the voltage vector applied during the last period, the measured current, the current one period earlier, the reference current for the end of the next period, and the inductance-over-period factor K. From these it estimates the voltage that does not come from the inductance. It also forms the voltage change that the current error calls for.

An active vector is applied only if it moves the current toward its reference, as seen from the tip of the non-inductive voltage. If none does, or if the error is negligible, a zero state is applied. The zero state chosen is the one that toggles the fewest legs from the previous output, which cuts switching losses. The result is registered and appears with a one-cycle valid pulse a fixed two clocks after the sample strobe.

Top module: `vsel_top`

## Requirements
- R1: While reset is asserted, and until the first result after reset, `gate_abc` is 000 and `out_vld` is low.
- R2: Every cycle with `smp_stb` high produces exactly one cycle of `out_vld` two clock edges later. `out_vld` is never high otherwise, and `gate_abc` changes only in cycles where `out_vld` is high.
- R3: The non-inductive voltage is V1 = u − K·(i − i_prev) and the error drive is E = K·(i_ref − i), per axis, computed without overflow for all input values.
- R4: The six active directions, scaled by 8, are (8,0), (4,7), (−4,7), (−8,0), (−4,−7), (4,−7). Their gate codes {a,b,c} are 100, 110, 010, 011, 001 and 101. The block selects the direction with the largest dot product with E, and the lowest index wins a tie.
- R5: The selected active vector is output only when VMAG·(dir·E) > 8·(V1·E), with VMAG = 12 by default. Otherwise a zero state is output.
- R6: When |E_x| + |E_y| < `err_thr`, a zero state is output regardless of R4 and R5.
- R7: A zero state is 111 if the previous output had two or more legs high, and 000 otherwise. After reset, the previous output counts as 000.
- R8: Strobes on consecutive cycles each produce a result, in order. Each zero-state decision uses the result issued immediately before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | Sample strobe; inputs are taken in this cycle |
| u_x | input | W | Applied voltage, x axis, signed |
| u_y | input | W | Applied voltage, y axis, signed |
| i_x | input | W | Present current, x axis, signed |
| i_y | input | W | Present current, y axis, signed |
| ip_x | input | W | Previous-period current, x axis, signed |
| ip_y | input | W | Previous-period current, y axis, signed |
| ir_x | input | W | Reference current for next period, x axis, signed |
| ir_y | input | W | Reference current for next period, y axis, signed |
| lts | input | KW | Inductance over sampling period factor K, unsigned |
| err_thr | input | W+KW+4 | Error-magnitude threshold (L1 norm of E), unsigned |
| gate_abc | output | 3 | Gate bits {a,b,c}, high means upper switch on |
| out_vld | output | 1 | One-cycle pulse when a new state is issued |

## Verification
The assertions check the timing contract on every cycle: the two-cycle strobe-to-valid relation, the absence of stray valids, the holding of the gates between results, the idle reset state, and the zero-state choice against the previous output. The vector arithmetic, meaning the observer equations, the direction argmax with its tie order, the suitability test and the threshold, can only be shown by the bench scenarios. These scenarios compare every output against an integer model, for directed corner cases and a long pseudo-random run.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

  // Active direction k (0..5) at k*60 degrees, scaled by 8.
  function automatic logic signed [4:0] dir_x(input int k);
    case (k)
      0: dir_x = 5'sd8;
      1: dir_x = 5'sd4;
      2: dir_x = -5'sd4;
      3: dir_x = -5'sd8;
      4: dir_x = -5'sd4;
      default: dir_x = 5'sd4;
    endcase
  endfunction

  function automatic logic signed [4:0] dir_y(input int k);
    case (k)
      0: dir_y = 5'sd0;
      1: dir_y = 5'sd7;
      2: dir_y = 5'sd7;
      3: dir_y = 5'sd0;
      4: dir_y = -5'sd7;
      default: dir_y = -5'sd7;
    endcase
  endfunction

  // Gate code {a,b,c} of direction k.
  function automatic logic [2:0] gate_code(input int k);
    case (k)
      0: gate_code = 3'b100;
      1: gate_code = 3'b110;
      2: gate_code = 3'b010;
      3: gate_code = 3'b011;
      4: gate_code = 3'b001;
      default: gate_code = 3'b101;
    endcase
  endfunction

endpackage

// File: rtl/vsel_observer.sv
// Non-inductive voltage V1 and error drive E (R3), plus L1 norm of E.
module vsel_observer #(
  parameter int W  = 5,
  parameter int KW = 6,
  parameter int VW = 14
) (
  input  logic signed [W-1:0]  u_x,
  input  logic signed [W-1:0]  u_y,
  input  logic signed [W-1:0]  i_x,
  input  logic signed [W-1:0]  i_y,
  input  logic signed [W-1:0]  ip_x,
  input  logic signed [W-1:0]  ip_y,
  input  logic signed [W-1:0]  ir_x,
  input  logic signed [W-1:0]  ir_y,
  input  logic [KW-1:0]        lts,
  output logic signed [VW-1:0] v1_x,
  output logic signed [VW-1:0] v1_y,
  output logic signed [VW-1:0] er_x,
  output logic signed [VW-1:0] er_y,
  output logic [VW:0]          er_l1
);
  localparam int DW = W + 1;

  logic signed [DW-1:0] dn_x, dn_y, dr_x, dr_y;
  logic signed [VW-1:0] kk;
  logic [VW-1:0]        mag_x, mag_y;

  assign kk = VW'($signed({1'b0, lts}));

  always_comb begin
    dn_x  = DW'(i_x) - DW'(ip_x);
    dn_y  = DW'(i_y) - DW'(ip_y);
    dr_x  = DW'(ir_x) - DW'(i_x);
    dr_y  = DW'(ir_y) - DW'(i_y);
    v1_x  = VW'(u_x) - kk * VW'(dn_x);
    v1_y  = VW'(u_y) - kk * VW'(dn_y);
    er_x  = kk * VW'(dr_x);
    er_y  = kk * VW'(dr_y);
    mag_x = er_x[VW-1] ? VW'(-er_x) : VW'(er_x);
    mag_y = er_y[VW-1] ? VW'(-er_y) : VW'(er_y);
    er_l1 = {1'b0, mag_x} + {1'b0, mag_y};
  end
endmodule

// File: rtl/vsel_pick.sv
// Direction argmax over the six active vectors (R4) and suitability test (R5).
module vsel_pick #(
  parameter int VW   = 14,
  parameter int VMAG = 12
) (
  input  logic signed [VW-1:0] v1_x,
  input  logic signed [VW-1:0] v1_y,
  input  logic signed [VW-1:0] er_x,
  input  logic signed [VW-1:0] er_y,
  output logic [2:0]           act_code,
  output logic                 act_ok
);
  localparam int ACW  = 2 * VW + 8;
  localparam int NDIR = 6;

  logic signed [ACW-1:0] dotv [NDIR];
  logic signed [ACW-1:0] best, v1dot, lhs, rhs;

  for (genvar gk = 0; gk < NDIR; gk++) begin : g_dir
    localparam logic signed [4:0] DX = vsel_pkg::dir_x(gk);
    localparam logic signed [4:0] DY = vsel_pkg::dir_y(gk);
    assign dotv[gk] = ACW'(DX) * ACW'(er_x) + ACW'(DY) * ACW'(er_y);
  end

  always_comb begin
    best     = dotv[0];
    act_code = vsel_pkg::gate_code(0);
    for (int k = 1; k < NDIR; k++) begin
      if (dotv[k] > best) begin
        best     = dotv[k];
        act_code = vsel_pkg::gate_code(k);
      end
    end
    v1dot  = ACW'(v1_x) * ACW'(er_x) + ACW'(v1_y) * ACW'(er_y);
    lhs    = ACW'(VMAG) * best;
    rhs    = v1dot <<< 3;
    act_ok = lhs > rhs;
  end
endmodule

// File: rtl/vsel_zero.sv
// Zero-state choice with fewest leg changes from the previous output (R7).
module vsel_zero (
  input  logic [2:0] prev_abc,
  output logic [2:0] zero_abc
);
  logic most_high;
  assign most_high = (prev_abc[0] & prev_abc[1]) | (prev_abc[1] & prev_abc[2]) |
                     (prev_abc[0] & prev_abc[2]);
  assign zero_abc  = most_high ? 3'b111 : 3'b000;
endmodule

// File: rtl/vsel_top.sv
module vsel_top #(
  parameter int W    = 5,
  parameter int KW   = 6,
  parameter int VMAG = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [W-1:0]  u_x,
  input  logic signed [W-1:0]  u_y,
  input  logic signed [W-1:0]  i_x,
  input  logic signed [W-1:0]  i_y,
  input  logic signed [W-1:0]  ip_x,
  input  logic signed [W-1:0]  ip_y,
  input  logic signed [W-1:0]  ir_x,
  input  logic signed [W-1:0]  ir_y,
  input  logic [KW-1:0]        lts,
  input  logic [W+KW+3:0]      err_thr,
  output logic [2:0]           gate_abc,
  output logic                 out_vld
);
  localparam int VW = W + KW + 3;
  localparam int NW = VW + 1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_m_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q_n, rst_m_n} <= 2'b00;
    else        {rst_q_n, rst_m_n} <= {rst_m_n, 1'b1};
  end

  // Stage 0: observer
  logic signed [VW-1:0] v1x_c, v1y_c, erx_c, ery_c;
  logic [NW-1:0]        l1_c;
  logic                 small_c;

  vsel_observer #(.W(W), .KW(KW), .VW(VW)) i_obs (
    .u_x(u_x), .u_y(u_y), .i_x(i_x), .i_y(i_y),
    .ip_x(ip_x), .ip_y(ip_y), .ir_x(ir_x), .ir_y(ir_y),
    .lts(lts), .v1_x(v1x_c), .v1_y(v1y_c), .er_x(erx_c), .er_y(ery_c),
    .er_l1(l1_c)
  );
  assign small_c = l1_c < err_thr;

  // Stage 1 registers
  logic                 s1_vld_q, s1_vld_d, s1_small_q;
  logic signed [VW-1:0] s1_v1x_q, s1_v1y_q, s1_erx_q, s1_ery_q;

  assign s1_vld_d = smp_stb;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_vld_q   <= 1'b0;
      s1_small_q <= 1'b0;
      s1_v1x_q   <= '0;
      s1_v1y_q   <= '0;
      s1_erx_q   <= '0;
      s1_ery_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (smp_stb) begin
        s1_small_q <= small_c;
        s1_v1x_q   <= v1x_c;
        s1_v1y_q   <= v1y_c;
        s1_erx_q   <= erx_c;
        s1_ery_q   <= ery_c;
      end
    end
  end

  // Stage 1 decision
  logic [2:0] act_code, zero_code;
  logic       act_ok;

  vsel_pick #(.VW(VW), .VMAG(VMAG)) i_pick (
    .v1_x(s1_v1x_q), .v1_y(s1_v1y_q), .er_x(s1_erx_q), .er_y(s1_ery_q),
    .act_code(act_code), .act_ok(act_ok)
  );

  vsel_zero i_zero (.prev_abc(gate_abc), .zero_abc(zero_code));

  // Stage 2 registers
  logic [2:0] gate_d;
  logic       vld_d;

  always_comb begin
    vld_d  = s1_vld_q;
    gate_d = gate_abc;
    if (s1_vld_q) gate_d = (s1_small_q || !act_ok) ? zero_code : act_code;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      gate_abc <= 3'b000;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= vld_d;
      if (s1_vld_q) gate_abc <= gate_d;
    end
  end
endmodule

// File: rtl/vsel_chk.sv
module vsel_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       smp_stb,
  input logic [2:0] gate_abc,
  input logic       out_vld
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_q_n |-> (gate_abc == 3'b000) && !out_vld);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    smp_stb |=> ##1 out_vld);

  assert_no_stray_vld_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_vld |-> $past(smp_stb, 2));

  assert_hold_gates_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !out_vld |-> $stable(gate_abc));

  assert_zero_pick_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld && (gate_abc == 3'b000 || gate_abc == 3'b111)) |->
      (gate_abc == (($countones($past(gate_abc)) >= 2) ? 3'b111 : 3'b000)));
endmodule

bind vsel_top vsel_chk i_vsel_chk (
  .clk(clk), .rst_q_n(rst_q_n), .smp_stb(smp_stb),
  .gate_abc(gate_abc), .out_vld(out_vld)
);

// File: tb/test_vsel_top.sv
`timescale 1ns/1ps
module test_vsel_top;
  localparam int W = 5, KW = 6, VMAG = 12, NW = W + KW + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, smp_stb;
  logic signed [W-1:0] u_x, u_y, i_x, i_y, ip_x, ip_y, ir_x, ir_y;
  logic [KW-1:0] lts;
  logic [NW-1:0] err_thr;
  logic [2:0] gate_abc;
  logic out_vld;

  vsel_top #(.W(W), .KW(KW), .VMAG(VMAG)) i_vsel_top (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .u_x(u_x), .u_y(u_y), .i_x(i_x), .i_y(i_y), .ip_x(ip_x), .ip_y(ip_y),
    .ir_x(ir_x), .ir_y(ir_y), .lts(lts), .err_thr(err_thr),
    .gate_abc(gate_abc), .out_vld(out_vld)
  );

  int n_chk = 0, n_fail = 0;
  int seed = 32'h1234_5678;
  int model_last = 0, exp_g = 0;
  int pv[3] = '{0, 0, 0};
  int pg[3] = '{0, 0, 0};
  string pt[3] = '{"", "", ""};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Behavioural reference for one sample.
  function automatic int ref_sel(input int ux, uy, ix, iy, px, py, rx, ry, k, thr, prev);
    int dxs[6] = '{8, 4, -4, -8, -4, 4};
    int dys[6] = '{0, 7, 7, 0, -7, -7};
    int cds[6] = '{4, 6, 2, 3, 1, 5};
    int v1x, v1y, ex, ey, best, bi, ones, zc, d;
    v1x = ux - k * (ix - px);
    v1y = uy - k * (iy - py);
    ex  = k * (rx - ix);
    ey  = k * (ry - iy);
    ones = (prev & 1) + ((prev >> 1) & 1) + ((prev >> 2) & 1);
    zc = (ones >= 2) ? 7 : 0;
    if (iabs(ex) + iabs(ey) < thr) return zc;
    best = dxs[0] * ex + dys[0] * ey;
    bi = 0;
    for (int j = 1; j < 6; j++) begin
      d = dxs[j] * ex + dys[j] * ey;
      if (d > best) begin best = d; bi = j; end
    end
    if (VMAG * best > 8 * (v1x * ex + v1y * ey)) return cds[bi];
    return zc;
  endfunction

  // One clock: compare outputs, then drive the next inputs.
  task automatic step(input bit stb, input int ux, uy, ix, iy, px, py, rx, ry, k, thr,
                      input string tag);
    @(negedge clk);
    pv[2] = pv[1]; pg[2] = pg[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pg[1] = pg[0]; pt[1] = pt[0];
    pv[0] = 0;
    if (pv[2] != 0) exp_g = pg[2];
    chk(out_vld == (pv[2] != 0), "R2 valid timing", int'(out_vld), pv[2]);
    chk(gate_abc == exp_g[2:0], (pv[2] != 0) ? pt[2] : "R2 hold", int'(gate_abc), exp_g);
    smp_stb = stb;
    u_x = ux[W-1:0]; u_y = uy[W-1:0]; i_x = ix[W-1:0]; i_y = iy[W-1:0];
    ip_x = px[W-1:0]; ip_y = py[W-1:0]; ir_x = rx[W-1:0]; ir_y = ry[W-1:0];
    lts = k[KW-1:0]; err_thr = thr[NW-1:0];
    if (stb) begin
      model_last = ref_sel(ux, uy, ix, iy, px, py, rx, ry, k, thr, model_last);
      pv[0] = 1; pg[0] = model_last; pt[0] = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  function automatic int rnd(input int n);
    seed = seed * 1103515245 + 12345;
    return ((seed >> 8) & 32'h00FF_FFFF) % n;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R2: watchdog expired, actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; smp_stb = 1'b0;
    u_x = '0; u_y = '0; i_x = '0; i_y = '0; ip_x = '0; ip_y = '0;
    ir_x = '0; ir_y = '0; lts = '0; err_thr = '0;
    #1 rst_n = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(gate_abc == 3'b000 && !out_vld, "R1 reset state", int'(gate_abc), 0);
    end
    rst_n = 1'b1;
    idle(4);

    // R4: pure direction along x -> 100
    step(1, 0, 0, 0, 0, 0, 0, 3, 0, 4, 0, "R4 dir 0deg");
    idle(3);
    // R4: tie between 60 and 120 degrees, lowest index -> 110
    step(1, 0, 0, 0, 0, 0, 0, 0, 3, 4, 0, "R4 tie low index");
    idle(3);
    // R5, R7: unsuitable after 110 -> 111, then again -> 111
    step(1, 15, 0, 0, 0, 0, 0, 3, 0, 4, 0, "R5 R7 zero after 110");
    idle(2);
    step(1, 15, 0, 0, 0, 0, 0, 3, 0, 4, 0, "R7 zero after 111");
    idle(3);
    // R4: 240 degrees -> 001
    step(1, 0, 0, 0, 0, 0, 0, -3, -2, 4, 0, "R4 dir 240deg");
    idle(3);
    // R6: small error under threshold, prev 001 -> 000
    step(1, 0, 0, 0, 0, 0, 0, 3, 0, 4, 20, "R6 threshold zero");
    idle(3);
    // R6 boundary: norm equals threshold -> active
    step(1, 0, 0, 0, 0, 0, 0, 3, 0, 4, 12, "R6 at threshold");
    idle(3);
    // R3: i_prev shifts V1 and makes vector suitable
    step(1, 15, 0, 2, 0, -2, 0, 5, 0, 4, 0, "R3 prev current");
    idle(3);
    step(1, 15, 0, 2, 0, 2, 0, 5, 0, 4, 0, "R3 R5 unsuitable");
    idle(3);
    // R3: extreme values
    step(1, -16, 15, 15, -16, -16, 15, -16, 15, 63, 0, "R3 extremes");
    idle(3);
    step(1, 15, -16, -16, 15, 15, -16, 15, -16, 63, 0, "R3 extremes neg");
    idle(3);
    // R8: back-to-back strobes
    step(1, 0, 0, 0, 0, 0, 0, 3, 3, 4, 0, "R8 burst a");
    step(1, 15, 15, 0, 0, 0, 0, 3, 3, 4, 0, "R8 burst b");
    step(1, 0, 0, 0, 0, 0, 0, -3, 0, 4, 0, "R8 burst c");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4, 0, "R8 burst d");
    idle(4);

    // Pseudo-random run covering R3 to R8
    for (int n = 0; n < 600; n++) begin
      step(rnd(3) != 0, rnd(32) - 16, rnd(32) - 16, rnd(32) - 16, rnd(32) - 16,
           rnd(32) - 16, rnd(32) - 16, rnd(32) - 16, rnd(32) - 16, rnd(64),
           (rnd(4) == 0) ? rnd(400) : 0, "R4 R5 R6 R7 random");
    end
    idle(4);
    finish_run();
  end
endmodule